// File: doc/BRIEF.md
# Fixed-Priority Request Encoder with Exclusive Mode

This block turns a small vector of request lines into a binary code and two status flags. In priority mode it reports the index of the highest-numbered active request. Line 3 outranks line 2, line 2 outranks line 1, and line 1 outranks line 0. A request-present flag and a request-absent flag go with the code, so a consumer can tell code 0 from "nothing asked". A typical use is a request/grant arbiter with a fixed ranking.

In exclusive mode the same request vector is checked for a single active line. When exactly one line is high, the output is that line's index plus one. In every other case the output is zero, so the value 0 means "invalid or empty".

The block has no storage. Every output follows its inputs combinationally. A mode input picks between the two interpretations of the shared code output.

Top module: `penc_core`

## Requirements
- R1: In priority mode (mode_i = 0) with two or more requests active, code_o equals the index of the highest-numbered active request line.
- R2: In priority mode with no request active, code_o is 0.
- R3: any_o is 1 exactly when at least one request line is high.
- R4: none_o is 1 exactly when no request line is high. It is always the complement of any_o.
- R5: In exclusive mode (mode_i = 1) with exactly one request active, code_o equals that line's index plus one (line 0 gives 1, line 3 gives 4).
- R6: In exclusive mode with zero requests, or with two or more, code_o is 0.
- R7: In priority mode the most significant bit of code_o is 0, so the code never exceeds NUM_REQ-1.
- R8: In priority mode with exactly one request active, code_o equals that line's index.
- R9: any_o and none_o depend only on req_i and are the same in both modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| req_i | input | NUM_REQ (4) | Request lines; bit k is request k |
| mode_i | input | 1 | 0 selects priority encoding, 1 selects exclusive encoding |
| code_o | output | OUT_W (3) | Encoded result for the selected mode |
| any_o | output | 1 | High when at least one request is active |
| none_o | output | 1 | High when no request is active |

## Verification
The assertions assume that req_i and mode_i hold steady long enough for the combinational outputs to settle. They check only values that are consistent with the inputs at that moment. The stimulus changes the inputs once per clock, just after the rising edge, and reads the results at the falling edge. The bench drives all sixteen request patterns in both modes, so the zero-active, single-active and multi-active cases are all reached. No input value outside the defined encodings exists, because mode_i is a single bit.

// File: rtl/penc_pkg.sv
// Package: shared types for the request encoder.
// Holds the mode encoding used by the top and the checker.
package penc_pkg;

    typedef enum logic {
        ENC_PRIO = 1'b0,
        ENC_EXCL = 1'b1
    } enc_mode_e;

endpackage

// File: rtl/penc_scan.sv
// Module: penc_scan
// Finds the highest-numbered set bit of the request vector.
// Assumes NUM_REQ >= 2. When no bit is set, idx_o is 0.
module penc_scan #(
    parameter int NUM_REQ = 4,
    localparam int IDX_W  = $clog2(NUM_REQ)
) (
    input  logic [NUM_REQ-1:0] req_i,
    output logic [IDX_W-1:0]   idx_o
);

    // Walk upward so that the last set bit seen (the highest) wins.
    always_comb begin
        idx_o = '0;
        for (int k = 0; k < NUM_REQ; k++) begin
            if (req_i[k]) begin
                idx_o = IDX_W'(k);
            end
        end
    end

endmodule

// File: rtl/penc_single.sv
// Module: penc_single
// Detects a request vector with exactly one bit set.
// Uses the clear-lowest-bit identity, so no population count is needed.
module penc_single #(
    parameter int NUM_REQ = 4
) (
    input  logic [NUM_REQ-1:0] req_i,
    output logic               one_o
);

    logic [NUM_REQ-1:0] low_cleared;

    // Remove the lowest set bit. The result is zero for at most one bit set.
    always_comb begin
        low_cleared = req_i & (req_i - NUM_REQ'(1));
        one_o       = (req_i != '0) && (low_cleared == '0);
    end

endmodule

// File: rtl/penc_flags.sv
// Module: penc_flags
// Produces the request-present and request-absent flags.
// Independent of the encoding mode.
module penc_flags #(
    parameter int NUM_REQ = 4
) (
    input  logic [NUM_REQ-1:0] req_i,
    output logic               any_o,
    output logic               none_o
);

    // OR-reduce the requests and drive both polarities.
    always_comb begin
        any_o  = |req_i;
        none_o = ~(|req_i);
    end

endmodule

// File: rtl/penc_core.sv
// Module: penc_core (top)
// Combinational request encoder with a priority mode and an exclusive mode.
// Assumes the inputs are stable whenever the outputs are consumed. Holds no state.
module penc_core
    import penc_pkg::*;
#(
    parameter int NUM_REQ = 4,
    localparam int IDX_W  = $clog2(NUM_REQ),
    localparam int OUT_W  = $clog2(NUM_REQ + 1)
) (
    input  logic [NUM_REQ-1:0] req_i,
    input  logic               mode_i,
    output logic [OUT_W-1:0]   code_o,
    output logic               any_o,
    output logic               none_o
);

    enc_mode_e        mode;
    logic [IDX_W-1:0] top_idx;
    logic             single;

    // Convert the plain mode pin to the package type.
    always_comb mode = enc_mode_e'(mode_i);

    penc_scan #(.NUM_REQ(NUM_REQ)) scan_i (
        .req_i (req_i),
        .idx_o (top_idx)
    );

    penc_single #(.NUM_REQ(NUM_REQ)) single_i (
        .req_i (req_i),
        .one_o (single)
    );

    penc_flags #(.NUM_REQ(NUM_REQ)) flags_i (
        .req_i  (req_i),
        .any_o  (any_o),
        .none_o (none_o)
    );

    // Choose the code interpretation for the selected mode.
    always_comb begin
        if (mode == ENC_EXCL) begin
            code_o = single ? (OUT_W'(top_idx) + OUT_W'(1)) : '0;
        end else begin
            code_o = OUT_W'(top_idx);
        end
    end

endmodule

// File: rtl/penc_core_chk.sv
// Module: penc_core_chk
// Assertion checker bound to penc_core. The block has no clock, so it uses
// immediate assertions that are evaluated whenever the inputs or outputs change.
module penc_core_chk #(
    parameter int NUM_REQ = 4,
    localparam int OUT_W  = $clog2(NUM_REQ + 1)
) (
    input logic [NUM_REQ-1:0] req_i,
    input logic               mode_i,
    input logic [OUT_W-1:0]   code_o,
    input logic               any_o,
    input logic               none_o
);

    int unsigned n_act;
    int unsigned cval;

    // Evaluate the output relations against the current inputs.
    always_comb begin
        n_act = $countones(req_i);
        cval  = int'(code_o);
        AST_FLAG_COMPL: assert (any_o != none_o) else $error("flags not complementary"); // R4
        AST_ANY_ACTIVE: assert (any_o == (n_act != 0)) else $error("any flag wrong"); // R3
        if (!mode_i) begin
            AST_PRIO_RANGE: assert (cval < NUM_REQ) else $error("priority code out of range"); // R7
            if (n_act != 0) begin
                AST_PRIO_HIT: assert (cval < NUM_REQ && req_i[cval % NUM_REQ]) else $error("code not active"); // R1
                AST_PRIO_HIGHEST: assert ((req_i >> (cval + 1)) == '0) else $error("higher request ignored"); // R1
            end else begin
                AST_PRIO_IDLE: assert (cval == 0) else $error("idle code nonzero"); // R2
            end
        end else begin
            if (n_act == 1) begin
                AST_EXCL_HIT: assert (cval >= 1 && cval <= NUM_REQ && req_i[(cval + NUM_REQ - 1) % NUM_REQ]) else $error("exclusive code wrong"); // R5
            end else begin
                AST_EXCL_ZERO: assert (cval == 0) else $error("exclusive code nonzero"); // R6
            end
        end
    end

endmodule

bind penc_core penc_core_chk #(.NUM_REQ(NUM_REQ)) chk_i (
    .req_i  (req_i),
    .mode_i (mode_i),
    .code_o (code_o),
    .any_o  (any_o),
    .none_o (none_o)
);

// File: tb/penc_core_tb_top.sv
// Scoreboard bench: the driver pushes expected results, the monitor compares them.
module penc_core_tb_top;

    localparam int N = 4;
    localparam int W = 3;

    typedef struct {
        logic [N-1:0] req;
        logic         mode;
        logic [W-1:0] code;
        logic         any;
        string        tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] req = '0;
    logic         mode = 1'b0;
    logic [W-1:0] code;
    logic         any_f;
    logic         none_f;

    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done = 1'b0;
    exp_t sb_q[$];

    always #4ns clk = ~clk;

    penc_core #(.NUM_REQ(N)) dut_i (
        .req_i  (req),
        .mode_i (mode),
        .code_o (code),
        .any_o  (any_f),
        .none_o (none_f)
    );

    // Count one comparison and report a mismatch.
    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Driver: apply one pattern and push the reference result.
    task automatic drive(input logic [N-1:0] r, input logic m);
        exp_t e;
        int   cnt = 0;
        int   hi = 0;
        for (int k = 0; k < N; k++) begin
            if (r[k]) begin
                cnt++;
                hi = k;
            end
        end
        e.req  = r;
        e.mode = m;
        e.any  = (cnt != 0);
        if (m) begin
            e.code = (cnt == 1) ? W'(hi + 1) : '0;
            e.tag  = (cnt == 1) ? "R5" : "R6";
        end else begin
            e.code = W'(hi);
            e.tag  = (cnt == 0) ? "R2" : ((cnt == 1) ? "R8" : "R1");
        end
        @(posedge clk);
        req  <= r;
        mode <= m;
        sb_q.push_back(e);
    endtask

    // Monitor: compare at the falling edge, once the inputs have settled.
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                check(e.tag, int'(code), int'(e.code));
                check(e.mode ? "R9 any" : "R3", int'(any_f), int'(e.any));
                check(e.mode ? "R9 none" : "R4", int'(none_f), int'(!e.any));
                if (!e.mode) check("R7", int'(code[W-1]), 0);
            end
        end
    end

    // Stimulus: idle first, then all patterns in both modes.
    initial begin
        repeat (2) @(posedge clk);
        rst_n <= 1'b1;
        drive('0, 1'b0);
        for (int m = 0; m < 2; m++) begin
            for (int p = 0; p < (1 << N); p++) begin
                drive(N'(p), m[0]);
            end
        end
        drive(4'b1111, 1'b0);
        drive(4'b1111, 1'b1);
        drive(4'b1000, 1'b1);
        drive(4'b0001, 1'b0);
        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule